// File: doc/BRIEF.md
# Vertical Line-Rate Scaler

This block changes the number of lines in a progressive video frame by a fractional ratio. It processes the frame one line at a time. A single line memory holds per-column state, and there is no frame store, so the output frame rate stays locked to the input frame rate. Every output line is an area-weighted or phase-weighted blend of neighbouring input lines. Lines are never dropped or duplicated, and every input line carries the same total weight.

A 16-bit coefficient sets the ratio, and a mode bit chooses its meaning. In reduce mode the coefficient is (output lines / input lines) x 65536. In enlarge mode it is (output lines / input lines - 1) x 65536. For example, 788 input lines reduced to 525 uses 43663 (0xAA8F). Pixels are 24 bits wide and hold three 8-bit channels in bits 23:16, 15:8 and 7:0. The three channels are processed identically and independently. In enlarge mode an input line can produce two output lines. The second one appears on a separate lane in the same cycles as the first. The downstream interlacer stores both lines.

Top module: `vline_scaler`

## Requirements
- R1: During reset, and after reset until the first accepted pixel, out_a_valid, out_b_valid and out_line_end are low.
- R2: Each output pixel appears exactly one clock after the accepted input pixel (pix_valid high) that produced it. A clock with pix_valid low produces no output valid on the next clock.
- R3: In reduce mode (up_mode=0), a 16-bit phase P is held across the frame. For each input line, S = P + coef. If S >= 65536, each pixel of that line produces one lane-A output pixel; otherwise the line produces no output. P becomes S mod 65536 after the line's last pixel. A frame of N lines therefore gives floor(N*coef/65536) output lines.
- R4: In reduce mode each channel with input x and column residue Rc produces floor((Rc + (65536-P)*x + 32768)/65536). After a line that emits, the residue becomes (S-65536)*x; otherwise it becomes Rc + coef*x. The residue counts as zero on the first line of a frame. A frame of one constant value therefore yields that value.
- R5: In enlarge mode (up_mode=1), every input line produces a lane-A line. When S >= 65536 it also produces a lane-B line in the same cycles, so N input lines give N + floor(N*coef/65536) output lines.
- R6: In enlarge mode, with q the same channel and column of the previous input line (or x itself on the first line of a frame), lane A is floor((q*P + x*(65536-P) + 32768)/65536). Lane B is the same expression with P replaced by S-65536.
- R7: frame_start on the first pixel of a frame resets P to 0 and discards the residue and previous line, so identical frames give identical output.
- R8: out_line_end is high with the last pixel of each emitted output line and only together with out_a_valid. out_b_valid is never high in reduce mode and is high only together with out_a_valid.
- R9: Idle cycles (pix_valid low) inside or between lines do not change any output value or line count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Input pixel accepted this cycle |
| pix_data | input | 24 | Three 8-bit channels of the input pixel |
| line_end | input | 1 | Marks the last pixel of an input line |
| frame_start | input | 1 | Marks the first pixel of a frame |
| coef | input | 16 | Scaling coefficient, held during a frame |
| up_mode | input | 1 | 1 = enlarge, 0 = reduce; held during a frame |
| out_a_valid | output | 1 | Lane-A output pixel valid |
| out_a_data | output | 24 | Lane-A output pixel |
| out_b_valid | output | 1 | Lane-B (extra enlarge line) pixel valid |
| out_b_data | output | 24 | Lane-B output pixel |
| out_line_end | output | 1 | Last pixel of the emitted output line(s) |

## Verification
Every result is due exactly one clock after the pixel that caused it, because the only register between input and output is the output stage. The bench drives each pixel on the falling edge. It computes that pixel's expected lane values from the requirement formulas at the same moment. It then compares all outputs one nanosecond after the next rising edge, so each comparison falls in the single cycle where the result is due. Line counts per frame are checked a few idle cycles after the last pixel. By then every output line has come out.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int CW    = 8;            // bits per channel
  localparam int FW    = 16;           // phase / coefficient bits
  localparam int NCH   = 3;            // channels per pixel
  localparam int PW    = CW * NCH;     // pixel width
  localparam int RW    = CW + FW;      // residue width per channel
  localparam int MW    = RW * NCH;     // line memory word
  localparam int TW    = RW + 2;       // arithmetic headroom

  typedef logic [CW-1:0] chan_t;
  typedef logic [FW:0]   wgt_t;
  typedef logic [RW-1:0] res_t;

  localparam wgt_t UNIT = wgt_t'(1) << FW;
  localparam logic [TW-1:0] HALF = TW'(1) << (FW - 1);

  // weighted mix of previous (q) and current (x) lines, wq on q
  function automatic chan_t mix(input chan_t q, input chan_t x, input wgt_t wq);
    logic [TW-1:0] t;
    t = TW'(q) * TW'(wq) + TW'(x) * TW'(UNIT - wq) + HALF;
    return t[FW +: CW];
  endfunction

  // close an output line: residue plus share w of the current line
  function automatic chan_t close_out(input res_t r, input wgt_t w, input chan_t x);
    logic [TW-1:0] t;
    t = TW'(r) + TW'(x) * TW'(w) + HALF;
    return t[FW +: CW];
  endfunction

  function automatic res_t seed(input logic [FW-1:0] w, input chan_t x);
    return res_t'(x) * res_t'(w);
  endfunction

  function automatic res_t accum(input res_t r, input chan_t x, input logic [FW-1:0] k);
    return r + res_t'(x) * res_t'(k);
  endfunction
endpackage

// File: rtl/vls_phase.sv
module vls_phase
  import vls_pkg::*;
#(
  parameter int COLW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_valid,
  input  logic            line_end,
  input  logic            frame_start,
  input  logic [FW-1:0]   coef,
  output logic [FW-1:0]   phase,
  output logic [FW-1:0]   next_frac,
  output logic            carry,
  output logic            first,
  output logic [COLW-1:0] col
);
  logic [FW-1:0]   acc_q;
  logic            first_q;
  logic [COLW-1:0] col_q;
  logic [FW:0]     sum;

  assign phase     = frame_start ? '0 : acc_q;
  assign sum       = {1'b0, phase} + {1'b0, coef};
  assign carry     = sum[FW];
  assign next_frac = sum[FW-1:0];
  assign first     = frame_start | first_q;
  assign col       = col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      first_q <= 1'b1;
      col_q   <= '0;
    end else if (pix_valid) begin
      if (line_end) begin
        acc_q   <= next_frac;
        first_q <= 1'b0;
        col_q   <= '0;
      end else begin
        col_q <= col_q + 1'b1;
        if (frame_start) begin
          acc_q   <= '0;
          first_q <= 1'b1;
        end
      end
    end
  end

  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && (line_end || frame_start)) |=> $stable(acc_q));

  // R7
  frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && frame_start && !line_end) |=> (acc_q == '0 && first_q));
endmodule

// File: rtl/vls_linemem.sv
module vls_linemem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 72,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/vls_blend.sv
module vls_blend
  import vls_pkg::*;
(
  input  logic          up_mode,
  input  logic          first,
  input  logic          carry,
  input  logic [FW-1:0] phase,
  input  logic [FW-1:0] next_frac,
  input  logic [FW-1:0] coef,
  input  logic [PW-1:0] pix,
  input  logic [MW-1:0] rd_word,
  output logic [MW-1:0] wr_word,
  output logic [PW-1:0] a_data,
  output logic [PW-1:0] b_data
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_t cur, prv;
    res_t  part;

    assign cur  = pix[g*CW +: CW];
    assign part = first ? '0 : rd_word[g*RW +: RW];
    assign prv  = first ? cur : rd_word[g*RW +: CW];

    assign a_data[g*CW +: CW] = up_mode ? mix(prv, cur, {1'b0, phase})
                                        : close_out(part, UNIT - {1'b0, phase}, cur);
    assign b_data[g*CW +: CW] = up_mode ? mix(prv, cur, {1'b0, next_frac}) : '0;
    assign wr_word[g*RW +: RW] = up_mode ? res_t'(cur)
                               : (carry ? seed(next_frac, cur) : accum(part, cur, coef));
  end
endmodule

// File: rtl/vline_scaler.sv
module vline_scaler
  import vls_pkg::*;
#(
  parameter int LINE_MAX = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic [23:0]   pix_data,
  input  logic          line_end,
  input  logic          frame_start,
  input  logic [15:0]   coef,
  input  logic          up_mode,
  output logic          out_a_valid,
  output logic [23:0]   out_a_data,
  output logic          out_b_valid,
  output logic [23:0]   out_b_data,
  output logic          out_line_end
);
  localparam int COLW = (LINE_MAX > 1) ? $clog2(LINE_MAX) : 1;

  logic [FW-1:0]   phase, next_frac;
  logic            carry, first;
  logic [COLW-1:0] col;
  logic [MW-1:0]   rd_word, wr_word;
  logic [PW-1:0]   a_mix, b_mix;
  logic            emit_a, emit_b;

  vls_phase #(.COLW(COLW)) phase_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_end(line_end),
    .frame_start(frame_start), .coef(coef), .phase(phase),
    .next_frac(next_frac), .carry(carry), .first(first), .col(col)
  );

  vls_linemem #(.DEPTH(LINE_MAX), .WIDTH(MW), .AW(COLW)) mem_i (
    .clk(clk), .we(pix_valid), .addr(col), .wdata(wr_word), .rdata(rd_word)
  );

  vls_blend blend_i (
    .up_mode(up_mode), .first(first), .carry(carry), .phase(phase),
    .next_frac(next_frac), .coef(coef), .pix(pix_data), .rd_word(rd_word),
    .wr_word(wr_word), .a_data(a_mix), .b_data(b_mix)
  );

  assign emit_a = pix_valid & (up_mode | carry);
  assign emit_b = pix_valid & up_mode & carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_a_valid  <= 1'b0;
      out_b_valid  <= 1'b0;
      out_line_end <= 1'b0;
      out_a_data   <= '0;
      out_b_data   <= '0;
    end else begin
      out_a_valid  <= emit_a;
      out_b_valid  <= emit_b;
      out_line_end <= emit_a & line_end;
      out_a_data   <= a_mix;
      out_b_data   <= b_mix;
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!out_a_valid && !out_b_valid));

  // R3
  down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !up_mode && !carry) |=> !out_a_valid);

  // R5
  up_every_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && up_mode) |=> out_a_valid);

  // R8
  down_no_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !up_mode) |=> !out_b_valid);

  // R8
  b_with_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_b_valid |-> out_a_valid);

  // R8
  end_with_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_line_end |-> out_a_valid);
endmodule

// File: tb/vline_scaler_tb.sv
`timescale 1ns/1ps
module vline_scaler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic        line_end = 1'b0;
  logic        frame_start = 1'b0;
  logic [15:0] coef_i = '0;
  logic        up_i = 1'b0;
  logic        out_a_valid, out_b_valid, out_line_end;
  logic [23:0] out_a_data, out_b_data;

  always #2 clk = ~clk;

  vline_scaler dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .line_end(line_end), .frame_start(frame_start), .coef(coef_i),
    .up_mode(up_i), .out_a_valid(out_a_valid), .out_a_data(out_a_data),
    .out_b_valid(out_b_valid), .out_b_data(out_b_data),
    .out_line_end(out_line_end)
  );

  int checks = 0, fails = 0;
  bit done = 0, started = 0;

  // reference state
  int part_m [3][64];
  int prev_m [3][64];
  int racc = 0, rx = 0;
  bit rfirst = 1;
  // expectation for the next sample
  bit e_pv = 0, e_a = 0, e_b = 0, e_le = 0;
  logic [23:0] e_ad = '0, e_bd = '0;
  int cnt_a = 0, cnt_b = 0;
  int const_watch = -1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 0; line_end = 0; frame_start = 0;
      e_pv = 0; e_a = 0; e_b = 0; e_le = 0;
    end
  endtask

  task automatic put_px(input logic [23:0] px, input bit le, input bit fs);
    int a, s, v, q, base, cf;
    @(negedge clk);
    pix_valid = 1; pix_data = px; line_end = le; frame_start = fs;
    cf = int'(coef_i);
    if (fs) begin racc = 0; rfirst = 1; end
    a = racc; s = a + cf;
    for (int ch = 0; ch < 3; ch++) begin
      v = int'(px[ch*8 +: 8]);
      if (!up_i) begin
        base = rfirst ? 0 : part_m[ch][rx];
        if (s >= 65536) begin
          e_ad[ch*8 +: 8] = 8'((base + (65536 - a) * v + 32768) / 65536);
          part_m[ch][rx] = (s - 65536) * v;
        end else begin
          part_m[ch][rx] = base + cf * v;
        end
      end else begin
        q = rfirst ? v : prev_m[ch][rx];
        e_ad[ch*8 +: 8] = 8'((q * a + v * (65536 - a) + 32768) / 65536);
        e_bd[ch*8 +: 8] = 8'((q * (s - 65536) + v * (131072 - s) + 32768) / 65536);
        prev_m[ch][rx] = v;
      end
    end
    e_pv = 1;
    e_a  = up_i || (s >= 65536);
    e_b  = up_i && (s >= 65536);
    e_le = e_a && le;
    rx++;
    if (le) begin racc = s % 65536; rfirst = 0; rx = 0; end
  endtask

  function automatic logic [23:0] pat(input int sd, input int ln, input int c);
    return {8'(sd + ln * 37 + c * 11), 8'(sd * 3 + ln * 53 + c * 7 + 90), 8'(ln * 29 + c * 41 + sd * 5)};
  endfunction

  task automatic send_frame(input int lines, input int width, input int sd,
                            input int cval, input bit gaps);
    for (int l = 0; l < lines; l++) begin
      for (int c = 0; c < width; c++) begin
        put_px(cval >= 0 ? {3{8'(cval)}} : pat(sd, l, c), c == width - 1, l == 0 && c == 0);
        if (gaps && (c % 2 == 1)) idle(1);   // R9 gaps inside the line
      end
      idle(2);
    end
    idle(3);
  endtask

  task automatic count_check(input string tag, input int na, input int nb);
    chk(cnt_a == na, {tag, " lane A line count"}, cnt_a, na);
    chk(cnt_b == nb, {tag, " lane B line count"}, cnt_b, nb);
    cnt_a = 0; cnt_b = 0;
  endtask

  // per-clock comparison against the reference, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (started && !done) begin
      chk(out_a_valid == e_a, e_pv ? (up_i ? "R5 lane A valid" : "R3 lane A valid") : "R2 idle A valid",
          int'(out_a_valid), int'(e_a));
      chk(out_b_valid == e_b, e_pv ? "R5 lane B valid" : "R2 idle B valid",
          int'(out_b_valid), int'(e_b));
      chk(out_line_end == e_le, "R8 line end", int'(out_line_end), int'(e_le));
      if (e_a && out_a_valid)
        chk(out_a_data == e_ad, up_i ? "R6 lane A data" : "R4 lane A data",
            int'(out_a_data), int'(e_ad));
      if (e_b && out_b_valid)
        chk(out_b_data == e_bd, "R6 lane B data", int'(out_b_data), int'(e_bd));
      if (const_watch >= 0 && out_a_valid)
        chk(out_a_data == {3{8'(const_watch)}}, "R4 constant frame kept",
            int'(out_a_data), const_watch * 65793);
      if (out_line_end) cnt_a++;
      if (out_line_end && out_b_valid) cnt_b++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!out_a_valid && !out_b_valid && !out_line_end, "R1 in reset", int'(out_a_valid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!out_a_valid && !out_b_valid && !out_line_end, "R1 after reset", int'(out_a_valid), 0);
    started = 1;

    // R3/R4: 788 -> 525 style reduce ratio
    up_i = 0; coef_i = 16'd43663;
    send_frame(12, 5, 1, -1, 0);
    count_check("R3", (12 * 43663) / 65536, 0);

    // R7: same frame again, phase must restart from zero
    send_frame(12, 5, 1, -1, 0);
    count_check("R7 repeat frame", (12 * 43663) / 65536, 0);

    // R4: half ratio on constant content reproduces the value
    coef_i = 16'd32768; const_watch = 200;
    send_frame(6, 4, 0, 200, 0);
    const_watch = -1;
    count_check("R4 half", 3, 0);

    // R4/R9: half ratio on varied content with gaps
    send_frame(7, 6, 9, -1, 1);
    count_check("R9 reduce gaps", 3, 0);

    // R5/R6: enlarge 1.5x with gaps
    up_i = 1; coef_i = 16'd32768;
    send_frame(8, 5, 4, -1, 1);
    count_check("R5 1.5x", 8, 4);

    // R6: coefficient zero passes lines straight through
    coef_i = 16'd0;
    send_frame(4, 5, 7, -1, 0);
    count_check("R6 unity", 4, 0);

    // R5/R6: enlarge by 4/3 over nine lines
    coef_i = 16'd21845;
    send_frame(9, 6, 2, -1, 0);
    count_check("R5 4/3", 9, (9 * 21845) / 65536);

    // R7: repeat enlarge frame
    send_frame(9, 6, 2, -1, 1);
    count_check("R7 enlarge repeat", 9, (9 * 21845) / 65536);

    done = 1;
    finish_run();
  end
endmodule